// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block watches a sliced, active-low composite sync stream together with the measured line period H, given in clock cycles. It finds the vertical interval and drives an active-low vertical sync pulse exactly 3H cycles long. The pulse starts as soon as a sync pulse has stayed low for more than a quarter line. That threshold catches the first wide serration pulse of a standard vertical interval. It also catches the single long low pulse of non-standard sync that has no serrations, so both kinds of input share one trigger path.

A free-running phase counter follows the line grid. The block classes each vertical interval by where its first wide pulse falls within the line: near line start it is field one, near mid-line it is field two. When the class alternates between two consecutive intervals, the stream is taken as interlaced. The field output then shows the field identity. For progressive input the field output stays high.

A qualifier output covers the whole vertical interval. Downstream horizontal logic uses it to mute its pulses. The qualifier runs from the vertical sync falling edge until the first normal-width sync pulse that ends after vertical sync has finished.

Top module: `vsd_vsync_detect`

## Requirements
- R1: `vsync_n` goes low at the clock edge where `csync_n` is sampled low for the (floor(H/4)+1)-th consecutive edge, counting the edge that first sees it low as edge 1.
- R2: Once low, `vsync_n` stays low for exactly 3H clock cycles and then returns high.
- R3: While `vint` is high, further wide pulses do not restart vertical sync, so one vertical interval produces exactly one `vsync_n` pulse.
- R4: A single uninterrupted low pulse longer than 3H, with no serrations, produces the same vertical sync as R1 and R2.
- R5: The line phase counts 0 to H-1 from the last sync fall taken as line start. A fall at phase p <= H/8 or p >= H-H/8 is line start and resets the phase. A fall with |p-H/2| <= H/8 is mid-line and leaves the phase running. Any other fall resets the phase and is unclassed. The first wide pulse of an interval is field one when its fall is a line start, field two when it is mid-line, and unclassed otherwise.
- R6: At each `vsync_n` falling edge, `interlaced` becomes 1 when this interval and the previous one are both classed and differ, and 0 in every other case.
- R7: `field_odd` is 1 for field one and 0 for field two while `interlaced` is 1. It is 1 whenever `interlaced` is 0.
- R8: `field_odd` and `interlaced` change only on the clock edge at which `vsync_n` falls.
- R9: `vint` rises on the same edge as the `vsync_n` fall and stays high while `vsync_n` is low. It falls on the edge that first samples `csync_n` high after a low pulse of at most floor(H/4) cycles, provided `vsync_n` was already high before that edge.
- R10: With `csync_n` held high, `vsync_n` stays high, `vint` stays low and `field_odd` keeps its value.
- R11: After reset, `vsync_n`=1, `field_odd`=1, `interlaced`=0 and `vint`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csync_n | input | 1 | Sliced composite sync, low during sync tips |
| line_period | input | HW | Measured line period H in clock cycles |
| vsync_n | output | 1 | Vertical sync, active low, 3H long |
| field_odd | output | 1 | High in field one or for progressive input, low in field two |
| interlaced | output | 1 | High while consecutive intervals alternate field class |
| vint | output | 1 | Vertical-interval qualifier for muting horizontal outputs |

## Verification
Vertical sync is due floor(H/4) edges after the first edge that samples the wide pulse low. The field and interlace outputs change on that same edge. The qualifier falls on the edge that sees the normal pulse rise. The bench keeps an edge counter and predicts each of these edge numbers from its own stimulus. It samples every output on the falling clock edge and compares the recorded edge numbers and pulse width with the prediction. A sweep at H=32 places the first wide pulse at every phase from 0 to 31 and compares field and interlace results with a class computed from the phase windows.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  // Classification of the first wide pulse of a vertical interval
  typedef enum logic [1:0] {
    FCLS_NONE = 2'd0,
    FCLS_ONE  = 2'd1,
    FCLS_TWO  = 2'd2
  } fcls_e;
endpackage

// File: rtl/vsd_pulse_meas.sv
module vsd_pulse_meas #(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csync_n,
  input  logic [HW-1:0] line_period,
  output logic          fall_o,
  output logic          broad_hit_o,
  output logic          rise_norm_o
);
  localparam int CW = HW + 2;
  localparam logic [CW-1:0] SAT = '1;

  logic          cs_d_q;
  logic [CW-1:0] lowcnt_q, lowcnt_d;
  logic          lowcnt_en;
  logic          fall, rise;
  logic [CW-1:0] quarter;

  always_comb begin
    fall      = cs_d_q & ~csync_n;
    rise      = ~cs_d_q & csync_n;
    quarter   = CW'(line_period >> 2);
    lowcnt_en = fall | (~csync_n & (lowcnt_q != SAT));
    lowcnt_d  = fall ? CW'(1) : lowcnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d_q   <= 1'b1;
      lowcnt_q <= '0;
    end else begin
      cs_d_q <= csync_n;
      if (lowcnt_en) lowcnt_q <= lowcnt_d;
    end
  end

  // low time just exceeded a quarter line on this edge
  assign fall_o      = fall;
  assign broad_hit_o = ~csync_n & ~fall & (lowcnt_q == quarter);
  assign rise_norm_o = rise & (lowcnt_q <= quarter);
endmodule

// File: rtl/vsd_phase_track.sv
module vsd_phase_track
  import vsd_pkg::*;
#(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall_i,
  input  logic [HW-1:0] line_period,
  output fcls_e         cls_o
);
  logic [HW-1:0] ph_q, ph_d, ph_inc;
  logic [HW-1:0] eighth, half;
  logic          near0, nearh;
  fcls_e         cls_q, cls_d;

  always_comb begin
    eighth = line_period >> 3;
    half   = line_period >> 1;
    ph_inc = (ph_q >= line_period - 1'b1) ? '0 : ph_q + 1'b1;
    near0  = (ph_inc <= eighth) || (ph_inc >= line_period - eighth);
    nearh  = (ph_inc >= half - eighth) && (ph_inc <= half + eighth);
    ph_d   = ph_inc;
    cls_d  = cls_q;
    if (fall_i) begin
      if (near0) begin
        ph_d  = '0;
        cls_d = FCLS_ONE;
      end else if (nearh) begin
        cls_d = FCLS_TWO;
      end else begin
        ph_d  = '0;
        cls_d = FCLS_NONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      cls_q <= FCLS_NONE;
    end else begin
      ph_q  <= ph_d;
      cls_q <= cls_d;
    end
  end

  assign cls_o = cls_q;
endmodule

// File: rtl/vsd_vsync_gen.sv
module vsd_vsync_gen #(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          broad_hit_i,
  input  logic          rise_norm_i,
  input  logic [HW-1:0] line_period,
  output logic          trig_o,
  output logic          vs_act_o,
  output logic          vint_o
);
  localparam int CW = HW + 2;

  logic [CW-1:0] vcnt_q, vcnt_d, span;
  logic          vs_q, vs_d;
  logic          vint_q, vint_d;
  logic          trig;

  always_comb begin
    span   = ({2'b00, line_period} << 1) + {2'b00, line_period} - CW'(1);
    trig   = broad_hit_i & ~vint_q;
    vs_d   = vs_q;
    vcnt_d = vcnt_q;
    vint_d = vint_q;
    if (trig) begin
      vs_d   = 1'b1;
      vcnt_d = span;
      vint_d = 1'b1;
    end else begin
      if (vs_q) begin
        if (vcnt_q == '0) vs_d = 1'b0;
        else              vcnt_d = vcnt_q - CW'(1);
      end
      if (vint_q & rise_norm_i & ~vs_q) vint_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q   <= 1'b0;
      vcnt_q <= '0;
      vint_q <= 1'b0;
    end else begin
      vs_q   <= vs_d;
      vcnt_q <= vcnt_d;
      vint_q <= vint_d;
    end
  end

  assign trig_o   = trig;
  assign vs_act_o = vs_q;
  assign vint_o   = vint_q;
endmodule

// File: rtl/vsd_field_track.sv
module vsd_field_track
  import vsd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  trig_i,
  input  fcls_e cls_i,
  output logic  field_odd_o,
  output logic  interlaced_o
);
  fcls_e prev_q, prev_d;
  logic  fo_q, fo_d;
  logic  il_q, il_d;
  logic  alt;

  always_comb begin
    alt    = (prev_q != FCLS_NONE) && (cls_i != FCLS_NONE) && (cls_i != prev_q);
    prev_d = prev_q;
    fo_d   = fo_q;
    il_d   = il_q;
    if (trig_i) begin
      prev_d = cls_i;
      il_d   = alt;
      fo_d   = alt ? (cls_i == FCLS_ONE) : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= FCLS_NONE;
      fo_q   <= 1'b1;
      il_q   <= 1'b0;
    end else begin
      prev_q <= prev_d;
      fo_q   <= fo_d;
      il_q   <= il_d;
    end
  end

  assign field_odd_o  = fo_q;
  assign interlaced_o = il_q;
endmodule

// File: rtl/vsd_vsync_detect.sv
module vsd_vsync_detect
  import vsd_pkg::*;
#(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csync_n,
  input  logic [HW-1:0] line_period,
  output logic          vsync_n,
  output logic          field_odd,
  output logic          interlaced,
  output logic          vint
);
  logic [1:0] rs_q;
  logic       rst_int_n;
  logic       fall, broad_hit, rise_norm, trig, vs_act;
  fcls_e      cls;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  vsd_pulse_meas #(.HW(HW)) i_meas (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .csync_n     (csync_n),
    .line_period (line_period),
    .fall_o      (fall),
    .broad_hit_o (broad_hit),
    .rise_norm_o (rise_norm)
  );

  vsd_phase_track #(.HW(HW)) i_phase (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .fall_i      (fall),
    .line_period (line_period),
    .cls_o       (cls)
  );

  vsd_vsync_gen #(.HW(HW)) i_vgen (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .broad_hit_i (broad_hit),
    .rise_norm_i (rise_norm),
    .line_period (line_period),
    .trig_o      (trig),
    .vs_act_o    (vs_act),
    .vint_o      (vint)
  );

  vsd_field_track i_field (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .trig_i       (trig),
    .cls_i        (cls),
    .field_odd_o  (field_odd),
    .interlaced_o (interlaced)
  );

  assign vsync_n = ~vs_act;
endmodule

// File: rtl/vsd_checker.sv
module vsd_checker #(
  parameter int HW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          csync_n,
  input logic [HW-1:0] line_period,
  input logic          vsync_n,
  input logic          field_odd,
  input logic          interlaced,
  input logic          vint
);
  localparam int CW = HW + 2;

  logic [CW-1:0] run_q;
  logic [CW-1:0] span;

  assign span = ({2'b00, line_period} << 1) + {2'b00, line_period};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (!vsync_n) begin
      if (run_q != '1) run_q <= run_q + 1'b1;
    end else           run_q <= '0;
  end

  AST_VS_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> !$past(csync_n)); // R1

  AST_VS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_n) |-> (run_q == span)); // R2

  AST_FIELD_ON_VS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field_odd) |-> $fell(vsync_n)); // R8

  AST_MODE_ON_VS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(interlaced) |-> $fell(vsync_n)); // R8

  AST_PROG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !interlaced |-> field_odd); // R7

  AST_VINT_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> vint); // R9

  AST_VINT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> $rose(vint)); // R9
endmodule

bind vsd_vsync_detect vsd_checker #(.HW(HW)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csync_n     (csync_n),
  .line_period (line_period),
  .vsync_n     (vsync_n),
  .field_odd   (field_odd),
  .interlaced  (interlaced),
  .vint        (vint)
);

// File: tb/test_vsd_vsync_detect.sv
module test_vsd_vsync_detect;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 12;
  localparam int NW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          csync_n;
  logic [HW-1:0] line_period;
  logic          vsync_n, field_odd, interlaced, vint;

  vsd_vsync_detect #(.HW(HW)) i_vsd_vsync_detect (
    .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .line_period(line_period),
    .vsync_n(vsync_n), .field_odd(field_odd), .interlaced(interlaced), .vint(vint)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int checks = 0, fails = 0;
  bit timed_out = 0;

  // output monitor, sampling away from the active edge
  int nfalls = 0, vfall_cyc = 0, vwidth = 0;
  bit fo_at_fall, il_at_fall, vint_at_fall, fo_before;
  bit vs_prev = 1'b1, fo_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (vs_prev && !vsync_n) begin
        nfalls++;
        vfall_cyc    = cyc;
        fo_at_fall   = field_odd;
        il_at_fall   = interlaced;
        vint_at_fall = vint;
        fo_before    = fo_prev;
      end
      if (!vs_prev && vsync_n) vwidth = cyc - vfall_cyc;
    end
    vs_prev = vsync_n;
    fo_prev = field_odd;
  end

  // reference model of field classification
  int m_prev = 0;
  bit m_il = 0, m_fo = 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cls_of(input int p, input int h);
    int q = h / 8;
    int hh = h / 2;
    if (p <= q || p >= h - q) return 1;
    if (p >= hh - q && p <= hh + q) return 2;
    return 0;
  endfunction

  task automatic model(input int c);
    bit alt = (m_prev != 0) && (c != 0) && (c != m_prev);
    m_il   = alt;
    m_fo   = alt ? (c == 1) : 1'b1;
    m_prev = c;
  endtask

  task automatic hold(input bit lvl, input int n);
    csync_n = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic normal_lines(input int n);
    int h = int'(line_period);
    repeat (n) begin
      hold(1'b0, NW);
      hold(1'b1, h - NW);
    end
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    csync_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_prev = 0; m_il = 0; m_fo = 1;
    chk(vsync_n == 1'b1,    "R11 vsync_n after reset",    vsync_n, 1);
    chk(field_odd == 1'b1,  "R11 field_odd after reset",  field_odd, 1);
    chk(interlaced == 1'b0, "R11 interlaced after reset", interlaced, 0);
    chk(vint == 1'b0,       "R11 vint after reset",       vint, 0);
  endtask

  // vertical interval whose first wide pulse starts o cycles after line start
  task automatic run_vi(input int o, input bit do_chk);
    int h = int'(line_period);
    int exp_fall, nf0;
    bit fo_old;
    hold(1'b1, o);
    exp_fall = cyc + 1 + h / 4;
    nf0      = nfalls;
    fo_old   = m_fo;
    model(cls_of(o, h));
    repeat (6) begin
      hold(1'b0, h / 2 - NW);
      hold(1'b1, NW);
    end
    hold(1'b1, (h - o % h) % h);
    normal_lines(3);
    if (do_chk) begin
      chk(nfalls - nf0 == 1,    "R3 one vsync per interval", nfalls - nf0, 1);
      chk(vfall_cyc == exp_fall, "R1 vsync fall edge", vfall_cyc, exp_fall);
      chk(vwidth == 3 * h,       "R2 vsync width", vwidth, 3 * h);
      chk(fo_at_fall == m_fo,    "R5 R7 field flag at vsync", fo_at_fall, m_fo);
      chk(il_at_fall == m_il,    "R6 interlaced at vsync", il_at_fall, m_il);
      chk(fo_before == fo_old,   "R8 field flag before vsync edge", fo_before, fo_old);
      chk(vint_at_fall == 1'b1,  "R9 vint with vsync", vint_at_fall, 1);
      chk(vint == 1'b0,          "R9 vint cleared after interval", vint, 0);
      chk(field_odd == m_fo,     "R7 field flag held", field_odd, m_fo);
    end
  endtask

  // non-standard interval: one long low pulse, no serrations
  task automatic run_long();
    int h = int'(line_period);
    int exp_fall, nf0;
    exp_fall = cyc + 1 + h / 4;
    nf0      = nfalls;
    model(1);
    hold(1'b0, 3 * h + h / 2);
    hold(1'b1, h / 2);
    chk(vint == 1'b1,    "R9 vint held past vsync", vint, 1);
    chk(vsync_n == 1'b1, "R4 vsync ended", vsync_n, 1);
    hold(1'b0, NW);
    chk(vint == 1'b1,    "R9 vint during normal pulse", vint, 1);
    hold(1'b1, 1);
    chk(vint == 1'b0,    "R9 vint cleared at normal rise", vint, 0);
    hold(1'b1, h - NW - 1);
    normal_lines(3);
    chk(nfalls - nf0 == 1,     "R4 one vsync for long pulse", nfalls - nf0, 1);
    chk(vfall_cyc == exp_fall, "R4 vsync fall edge", vfall_cyc, exp_fall);
    chk(vwidth == 3 * h,       "R4 vsync width", vwidth, 3 * h);
    chk(fo_at_fall == m_fo,    "R7 field flag long pulse", fo_at_fall, m_fo);
    chk(il_at_fall == m_il,    "R6 interlaced long pulse", il_at_fall, m_il);
  endtask

  task automatic run_all();
    int nf0;
    line_period = HW'(64);
    do_reset();
    normal_lines(3);
    run_vi(0, 1);
    run_vi(32, 1);
    nf0 = nfalls;
    hold(1'b1, 5 * 64);
    chk(nfalls == nf0,       "R10 no vsync when idle", nfalls - nf0, 0);
    chk(vsync_n == 1'b1,     "R10 vsync_n idle", vsync_n, 1);
    chk(field_odd == m_fo,   "R10 field flag kept", field_odd, m_fo);
    chk(vint == 1'b0,        "R10 vint idle", vint, 0);
    normal_lines(3);
    run_vi(0, 1);
    run_vi(0, 1);
    run_long();
    run_vi(32, 1);
    run_long();
    // phase sweep on a short line
    line_period = HW'(32);
    do_reset();
    normal_lines(3);
    for (int o = 0; o < 32; o++) begin
      run_vi(0, 0);
      run_vi(0, 0);
      run_vi(o, 1);
    end
  endtask

  initial begin
    rst_n       = 1'b0;
    csync_n     = 1'b1;
    line_period = HW'(64);
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule